// File: doc/BRIEF.md
# MESI Snooping Line Coherence Controller

This block holds the coherence state of every line of a small snooping cache and decides, for each processor request and each bus transaction observed from another cache, what happens to that line. Each line is Invalid, Shared, Exclusive (clean, only copy) or Modified (dirty, only copy). Processor reads, writes and evictions that the current state allows complete in the same cycle. Otherwise the controller posts one bus request and completes the processor request in the cycle the bus response arrives.

Observed bus traffic is handled every cycle. A remote read demotes a private copy to Shared. A remote read-for-ownership invalidates the copy. Whenever the local copy is Modified, an intervention strobe is raised so that this cache supplies the dirty data in place of memory. The shared signal is sampled with the fill response to choose between Exclusive and Shared. A snoop always wins over processor work on the same line, and the processor simply retries. The data array, tags and bus arbitration are outside this block; a line is addressed directly by its index.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_op` is 2'b00 and `supply` is low, so a first read of any line misses.
- R2: Processor op encoding is 2'b00 read, 2'b01 write, 2'b10 evict. A read to a Shared, Exclusive or Modified line raises `cpu_ready` in the same cycle, issues no bus request and leaves the state unchanged.
- R3: Bus op encoding is 2'b00 none, 2'b01 read-shared, 2'b10 read-exclusive, 2'b11 writeback. A read to an Invalid line posts 2'b01 on `bus_op` from the next cycle. In the cycle `bus_resp` is high `cpu_ready` rises, and the line becomes Shared if `bus_shared` is high and Exclusive if it is low.
- R4: A write to a Modified or Exclusive line completes in the same cycle with no bus request and leaves the line Modified. A write to a Shared or Invalid line posts 2'b10, and on the response the line becomes Modified.
- R5: Evicting a Modified line posts 2'b11 and leaves the line Invalid on the response. Evicting an Exclusive, Shared or Invalid line completes at once and leaves it Invalid.
- R6: A snooped read-shared (kind 2'b01) turns Modified into Shared with `supply` high in that cycle, and turns Exclusive into Shared. It leaves Shared and Invalid unchanged.
- R7: A snooped read-exclusive (kind 2'b10) makes any line Invalid, with `supply` high in that cycle only if the line was Modified.
- R8: Snoop kinds 2'b00 and 2'b11 change no state and never raise `supply`.
- R9: If a snoop and an idle processor request address the same line in one cycle, the snoop takes effect and `cpu_ready` stays low. The held request is served afterwards against the new state.
- R10: A snoop to the line of an outstanding bus request cancels it. `bus_op` returns to 2'b00 the next cycle without `cpu_ready`, and the held processor request is reissued.
- R11: A snoop to a different line neither cancels nor delays an outstanding request or an idle hit.
- R12: While a request is outstanding, `bus_op` and `bus_line` stay constant until the response or a cancelling snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid, held until `cpu_ready` |
| cpu_op | input | 2 | Processor operation (R2 encoding) |
| cpu_line | input | IDXW | Line index of the processor request |
| cpu_ready | output | 1 | Processor request completes this cycle |
| bus_op | output | 2 | Outstanding bus request (R3 encoding) |
| bus_line | output | IDXW | Line index of the outstanding bus request |
| bus_resp | input | 1 | Response to the outstanding bus request |
| bus_shared | input | 1 | Another cache holds the line, sampled with `bus_resp` |
| snoop_valid | input | 1 | A bus transaction from another cache is observed |
| snoop_kind | input | 2 | Kind of observed transaction (R3 encoding) |
| snoop_line | input | IDXW | Line index of the observed transaction |
| supply | output | 1 | Intervention: this cache supplies dirty data this cycle |

## Verification
The bench builds the block with four lines, the default. That is small enough to drive every line through every starting state, then every ordered pair of operations taken from the three processor ops and the four snoop kinds. The same shape is large enough to place conflicting and non-conflicting snoops beside an outstanding request. A reference table of line states in the bench predicts each hit, bus op, shared-driven fill result and intervention strobe. The state reached by one operation is therefore checked through the behaviour of the next.

// File: rtl/mesi_ctrl_pkg.sv
package mesi_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_t;

    typedef enum logic [1:0] {
        BUS_NONE = 2'b00,
        BUS_RDS  = 2'b01,
        BUS_RDX  = 2'b10,
        BUS_WB   = 2'b11
    } busop_t;

    localparam logic [1:0] OP_READ  = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_EVICT = 2'b10;

endpackage

// File: rtl/mesi_snoop_react.sv
module mesi_snoop_react
    import mesi_ctrl_pkg::*;
(
    input  logic       hit,
    input  logic [1:0] kind,
    input  mesi_t      cur,
    output mesi_t      nxt,
    output logic       dirty_supply
);
    always_comb begin
        nxt          = cur;
        dirty_supply = 1'b0;
        if (hit) begin
            unique case (busop_t'(kind))
                BUS_RDS: begin
                    dirty_supply = (cur == ST_M);
                    if (cur == ST_M || cur == ST_E) nxt = ST_S;
                end
                BUS_RDX: begin
                    dirty_supply = (cur == ST_M);
                    nxt          = ST_I;
                end
                default: nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/mesi_cpu_decide.sv
module mesi_cpu_decide
    import mesi_ctrl_pkg::*;
(
    input  logic [1:0] op,
    input  mesi_t      cur,
    output logic       hit,
    output mesi_t      hit_next,
    output busop_t     miss_op
);
    always_comb begin
        hit      = 1'b1;
        hit_next = cur;
        miss_op  = BUS_NONE;
        case (op)
            OP_READ: begin
                if (cur == ST_I) begin
                    hit     = 1'b0;
                    miss_op = BUS_RDS;
                end
            end
            OP_WRITE: begin
                if (cur == ST_M || cur == ST_E) begin
                    hit_next = ST_M;
                end else begin
                    hit     = 1'b0;
                    miss_op = BUS_RDX;
                end
            end
            OP_EVICT: begin
                if (cur == ST_M) begin
                    hit     = 1'b0;
                    miss_op = BUS_WB;
                end else begin
                    hit_next = ST_I;
                end
            end
            default: hit_next = cur;
        endcase
    end
endmodule

// File: rtl/mesi_fill_resolve.sv
module mesi_fill_resolve
    import mesi_ctrl_pkg::*;
(
    input  busop_t op,
    input  logic   shared_seen,
    output mesi_t  final_st
);
    always_comb begin
        case (op)
            BUS_RDS: final_st = shared_seen ? ST_S : ST_E;
            BUS_RDX: final_st = ST_M;
            default: final_st = ST_I;
        endcase
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_ctrl_pkg::*;
#(
    parameter int LINES = 4,
    localparam int IDXW = $clog2(LINES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_req,
    input  logic [1:0]      cpu_op,
    input  logic [IDXW-1:0] cpu_line,
    output logic            cpu_ready,
    output logic [1:0]      bus_op,
    output logic [IDXW-1:0] bus_line,
    input  logic            bus_resp,
    input  logic            bus_shared,
    input  logic            snoop_valid,
    input  logic [1:0]      snoop_kind,
    input  logic [IDXW-1:0] snoop_line,
    output logic            supply
);

    typedef struct packed {
        logic                  busy;
        busop_t                op;
        logic [IDXW-1:0]       line;
        mesi_t [LINES-1:0]     tbl;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    mesi_t             snp_next [LINES];
    logic [LINES-1:0]  snp_supply;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        mesi_snoop_react u_react (
            .hit          (snoop_valid && (snoop_line == IDXW'(g))),
            .kind         (snoop_kind),
            .cur          (ctrl_q.tbl[g]),
            .nxt          (snp_next[g]),
            .dirty_supply (snp_supply[g])
        );
    end

    logic   dec_hit;
    mesi_t  dec_next;
    busop_t dec_miss;
    mesi_t  fill_st;

    mesi_cpu_decide u_decide (
        .op       (cpu_op),
        .cur      (ctrl_q.tbl[cpu_line]),
        .hit      (dec_hit),
        .hit_next (dec_next),
        .miss_op  (dec_miss)
    );

    mesi_fill_resolve u_fill (
        .op          (ctrl_q.op),
        .shared_seen (bus_shared),
        .final_st    (fill_st)
    );

    logic snoop_on_cpu, snoop_on_pend;
    assign snoop_on_cpu  = snoop_valid && (snoop_line == cpu_line);
    assign snoop_on_pend = snoop_valid && (snoop_line == ctrl_q.line);

    always_comb begin
        ctrl_d    = ctrl_q;
        cpu_ready = 1'b0;
        for (int i = 0; i < LINES; i++) ctrl_d.tbl[i] = snp_next[i];
        if (!ctrl_q.busy) begin
            if (cpu_req && !snoop_on_cpu) begin
                if (dec_hit) begin
                    cpu_ready             = 1'b1;
                    ctrl_d.tbl[cpu_line]  = dec_next;
                end else begin
                    ctrl_d.busy = 1'b1;
                    ctrl_d.op   = dec_miss;
                    ctrl_d.line = cpu_line;
                end
            end
        end else if (snoop_on_pend) begin
            ctrl_d.busy = 1'b0;
            ctrl_d.op   = BUS_NONE;
        end else if (bus_resp) begin
            cpu_ready               = 1'b1;
            ctrl_d.tbl[ctrl_q.line] = fill_st;
            ctrl_d.busy             = 1'b0;
            ctrl_d.op               = BUS_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.busy <= 1'b0;
            ctrl_q.op   <= BUS_NONE;
            ctrl_q.line <= '0;
            for (int i = 0; i < LINES; i++) ctrl_q.tbl[i] <= ST_I;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign bus_op   = ctrl_q.op;
    assign bus_line = ctrl_q.line;
    assign supply   = |snp_supply;

    assert_supply_from_snoop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        supply |-> (snoop_valid && (snoop_kind == 2'b01 || snoop_kind == 2'b10)));

    assert_rdx_leaves_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && snoop_kind == 2'b10) |=> (ctrl_q.tbl[$past(snoop_line)] == ST_I));

    assert_conflict_blocks_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.busy && cpu_req && snoop_valid && snoop_line == cpu_line) |-> !cpu_ready);

    assert_cancel_on_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.busy && snoop_on_pend) |=> (bus_op == 2'b00));

    assert_hold_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.busy && !bus_resp && !snoop_on_pend)
        |=> (bus_op == $past(bus_op) && bus_line == $past(bus_line)));

    assert_rdx_fill_modified_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && ctrl_q.busy && ctrl_q.op == BUS_RDX)
        |=> (ctrl_q.tbl[$past(ctrl_q.line)] == ST_M));

    assert_busy_has_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.busy == (bus_op != 2'b00));

endmodule

// File: tb/mesi_line_ctrl_bench.sv
module mesi_line_ctrl_bench;
    localparam int LINES = 4;
    localparam int IDXW  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0;
    logic [1:0] cpu_op = 2'b00;
    logic [IDXW-1:0] cpu_line = '0;
    logic cpu_ready;
    logic [1:0] bus_op;
    logic [IDXW-1:0] bus_line;
    logic bus_resp = 1'b0, bus_shared = 1'b0;
    logic snoop_valid = 1'b0;
    logic [1:0] snoop_kind = 2'b00;
    logic [IDXW-1:0] snoop_line = '0;
    logic supply;

    int n_cmp = 0, n_bad = 0;
    int model [LINES];   // 0 I, 1 S, 2 E, 3 M

    always #4 clk = ~clk;

    mesi_line_ctrl #(.LINES(LINES)) u_mesi_line_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_op(cpu_op),
        .cpu_line(cpu_line), .cpu_ready(cpu_ready), .bus_op(bus_op),
        .bus_line(bus_line), .bus_resp(bus_resp), .bus_shared(bus_shared),
        .snoop_valid(snoop_valid), .snoop_kind(snoop_kind),
        .snoop_line(snoop_line), .supply(supply)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // processor operation with full model prediction
    task automatic do_cpu(input int op, input int ln, input bit shr);
        int st, eop, nst;
        bit hit;
        string tag;
        st = model[ln];
        hit = 1'b1; eop = 0; nst = st;
        if (op == 0) begin
            tag = "R2/R3";
            if (st == 0) begin hit = 1'b0; eop = 1; nst = shr ? 1 : 2; end
        end else if (op == 1) begin
            tag = "R4";
            if (st >= 2) nst = 3;
            else begin hit = 1'b0; eop = 2; nst = 3; end
        end else begin
            tag = "R5";
            if (st == 3) begin hit = 1'b0; eop = 3; end
            nst = 0;
        end
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = 2'(op); cpu_line = 2'(ln);
        #2;
        check(cpu_ready == hit, tag, cpu_ready, hit);
        check(bus_op == 2'b00, tag, bus_op, 0);
        if (!hit) begin
            @(negedge clk);
            bus_resp = 1'b1; bus_shared = shr;
            #2;
            check(bus_op == 2'(eop), tag, bus_op, eop);
            check(bus_line == 2'(ln), tag, bus_line, ln);
            check(cpu_ready == 1'b1, tag, cpu_ready, 1);
        end
        @(negedge clk);
        cpu_req = 1'b0; bus_resp = 1'b0; bus_shared = 1'b0;
        model[ln] = nst;
    endtask

    task automatic do_snoop(input int kind, input int ln);
        int st, nst;
        bit exp_sup;
        st = model[ln]; nst = st; exp_sup = 1'b0;
        if (kind == 1) begin
            exp_sup = (st == 3);
            if (st >= 2) nst = 1;
        end else if (kind == 2) begin
            exp_sup = (st == 3);
            nst = 0;
        end
        @(negedge clk);
        snoop_valid = 1'b1; snoop_kind = 2'(kind); snoop_line = 2'(ln);
        #2;
        check(supply == exp_sup, (kind == 1) ? "R6" : (kind == 2) ? "R7" : "R8",
              supply, exp_sup);
        @(negedge clk);
        snoop_valid = 1'b0;
        model[ln] = nst;
    endtask

    task automatic set_state(input int ln, input int s);
        do_snoop(2, ln);
        if (s == 1) do_cpu(0, ln, 1'b1);
        else if (s == 2) do_cpu(0, ln, 1'b0);
        else if (s == 3) do_cpu(1, ln, 1'b0);
    endtask

    task automatic apply(input int a, input int ln, input bit shr);
        if (a < 3) do_cpu(a, ln, shr);
        else do_snoop(a - 3, ln);
    endtask

    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        for (int i = 0; i < LINES; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        #2;
        check(bus_op == 2'b00, "R1", bus_op, 0);
        check(supply == 1'b0, "R1", supply, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < LINES; i++) do_cpu(0, i, 1'b0);   // R1 first reads miss

        // pairwise sweep: every line, start state, op pair
        for (int ln = 0; ln < LINES; ln++)
            for (int s = 0; s < 4; s++)
                for (int a = 0; a < 7; a++)
                    for (int b = 0; b < 7; b++) begin
                        set_state(ln, s);
                        apply(a, ln, 1'((ln + s) % 2));
                        apply(b, ln, 1'((a + b) % 2));
                    end

        // R9: snoop and idle request on same line
        set_state(0, 2);
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = 2'b00; cpu_line = 2'd0;
        snoop_valid = 1'b1; snoop_kind = 2'b01; snoop_line = 2'd0;
        #2;
        check(cpu_ready == 1'b0, "R9", cpu_ready, 0);
        @(negedge clk);
        snoop_valid = 1'b0;
        #2;
        check(cpu_ready == 1'b1, "R9", cpu_ready, 1);
        @(negedge clk);
        cpu_req = 1'b0;
        model[0] = 1;
        do_snoop(1, 0);   // Shared: no supply, R6

        // R10: snoop to pending line cancels
        set_state(1, 0);
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = 2'b01; cpu_line = 2'd1;
        @(negedge clk);
        snoop_valid = 1'b1; snoop_kind = 2'b10; snoop_line = 2'd1;
        #2;
        check(bus_op == 2'b10, "R10", bus_op, 2);
        check(cpu_ready == 1'b0, "R10", cpu_ready, 0);
        @(negedge clk);
        snoop_valid = 1'b0;
        #2;
        check(bus_op == 2'b00, "R10", bus_op, 0);
        check(cpu_ready == 1'b0, "R10", cpu_ready, 0);
        @(negedge clk);
        bus_resp = 1'b1;
        #2;
        check(bus_op == 2'b10, "R10", bus_op, 2);
        check(cpu_ready == 1'b1, "R10", cpu_ready, 1);
        @(negedge clk);
        cpu_req = 1'b0; bus_resp = 1'b0;
        model[1] = 3;

        // R11: snoop to other line during pending and during idle hit
        set_state(2, 3);
        set_state(3, 0);
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = 2'b00; cpu_line = 2'd3;
        @(negedge clk);
        snoop_valid = 1'b1; snoop_kind = 2'b01; snoop_line = 2'd2;
        #2;
        check(supply == 1'b1, "R11", supply, 1);
        check(bus_op == 2'b01, "R11", bus_op, 1);
        @(negedge clk);
        snoop_valid = 1'b0; bus_resp = 1'b1; bus_shared = 1'b1;
        #2;
        check(bus_op == 2'b01, "R11", bus_op, 1);
        check(cpu_ready == 1'b1, "R11", cpu_ready, 1);
        @(negedge clk);
        cpu_req = 1'b0; bus_resp = 1'b0; bus_shared = 1'b0;
        model[2] = 1; model[3] = 1;
        @(negedge clk);
        cpu_req = 1'b1; cpu_op = 2'b00; cpu_line = 2'd1;
        snoop_valid = 1'b1; snoop_kind = 2'b10; snoop_line = 2'd3;
        #2;
        check(cpu_ready == 1'b1, "R11", cpu_ready, 1);
        @(negedge clk);
        cpu_req = 1'b0; snoop_valid = 1'b0;
        model[3] = 0;
        do_cpu(0, 3, 1'b0);
        do_cpu(0, 2, 1'b0);
        report();
    end
endmodule